// File: doc/BRIEF.md
# Per-Source Row Batch Former

This block sits at the front of a memory scheduler. It gathers the requests of several sources, such as CPU cores and a graphics engine, into batches that keep to one DRAM row. Every source has its own in-order queue. Requests that follow one another from the same source and hit the same bank and row join one batch. A batch is closed in one of two ways: a request to another bank or row arrives, or the batch has been open for a programmable number of cycles. For each source, the block offers the head of the oldest closed batch to the stage that follows. It flags the final request of that batch, so the arbiter knows when its grant for that source ends.

When the whole block holds little work, batching only adds latency. A global bypass compares the total number of buffered requests with a programmable threshold. While the total is below the threshold, any open batch is closed at once, and each new request is closed on arrival, so it can leave on the next cycle.

Top module: `rowgroup_former`

## Requirements
- R1: Each source has its own first-in first-out queue. Requests leave a source in the order they entered it, and activity on one source never changes what another source offers.
- R2: A source's open batch is closed when that source enqueues a request whose bank or row differs from the open batch's bank and row. Equal row numbers in different banks count as different. The new request opens the next batch.
- R3: With window_len L of 2 or more, an open batch that no row change has closed becomes visible at the output L cycles after the clock edge that enqueued its first request. With L of 0 or 1, every request is a batch of its own and is visible on the cycle after its enqueue.
- R4: out_valid of a source is high only while that source holds at least one closed batch, and it then presents the oldest queued request. out_last is 1 exactly on the final request of a batch. Requests of a batch that is still open are never offered.
- R5: While the sum of all queue occupancies is strictly less than bypass_below, any open batch is closed on the next edge. Each request enqueued in that state is its own batch and is offered on the next cycle. A sum equal to the threshold does not bypass.
- R6: in_ready of a source is low exactly when its queue holds DEPTH entries, and a request presented while it is low is dropped. An enqueue and a dequeue on one queue in the same cycle are both performed.
- R7: After reset, every queue is empty, every out_valid is 0 and every in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| window_len | input | WIN_W | Batch formation window in cycles |
| bypass_below | input | TOT_W | Bypass when total occupancy is below this value |
| in_valid | input | NSRC | Per-source request valid |
| in_ready | output | NSRC | Per-source queue not full |
| in_bank | input | NSRC*BANK_W | Per-source request bank |
| in_row | input | NSRC*ROW_W | Per-source request row |
| in_tag | input | NSRC*TAG_W | Per-source request tag |
| out_valid | output | NSRC | Per-source closed batch available |
| out_ready | input | NSRC | Per-source dequeue of the head request |
| out_last | output | NSRC | Head request ends its batch |
| out_bank | output | NSRC*BANK_W | Head request bank |
| out_row | output | NSRC*ROW_W | Head request row |
| out_tag | output | NSRC*TAG_W | Head request tag |

## Verification
Row breaks are swept over every run length that fits in a queue. The last-of-batch flag must sit on exactly the final request of each run, and an open run must stay hidden. A second pattern uses a repeated row number in a different bank, which tells a bank-aware key apart from a row-only key. The window length is swept so that the cycle the output appears is measured against the arithmetic latency. Interleaved sources, a filled queue with a dropped extra request, a same-cycle enqueue and dequeue, and the bypass threshold at and just above the occupancy test independence, overflow and the strict comparison.

// File: rtl/rgf_pkg.sv
package rgf_pkg;

  // Window closes on the edge where the counter would reach the limit.
  function automatic logic window_done(input logic [31:0] cnt, input logic [31:0] len);
    return (cnt + 32'd1) >= len;
  endfunction

  // A window of 0 or 1 cycles means every request stands alone.
  function automatic logic single_shot(input logic [31:0] len);
    return len <= 32'd1;
  endfunction

  // Bypass is a strict less-than on the total occupancy.
  function automatic logic under_load(input logic [31:0] total, input logic [31:0] thr);
    return total < thr;
  endfunction

endpackage

// File: rtl/rgf_load_gauge.sv
module rgf_load_gauge #(
  parameter int NSRC  = 5,
  parameter int CW    = 5,
  parameter int TOT_W = 7
) (
  input  logic [NSRC*CW-1:0] occ,
  input  logic [TOT_W-1:0]   thr,
  output logic [TOT_W-1:0]   total,
  output logic               bypass
);
  import rgf_pkg::*;

  always_comb begin
    total = '0;
    for (int i = 0; i < NSRC; i++) begin
      total = total + TOT_W'(occ[i*CW +: CW]);
    end
  end

  assign bypass = under_load(32'(total), 32'(thr));

endmodule

// File: rtl/rgf_src_queue.sv
module rgf_src_queue #(
  parameter int DEPTH  = 16,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int TAG_W  = 6,
  parameter int WIN_W  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic [WIN_W-1:0]  window_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [TAG_W-1:0]  out_tag,
  output logic [CW-1:0]     occupancy
);
  import rgf_pkg::*;

  logic [BANK_W-1:0] mem_bank [DEPTH];
  logic [ROW_W-1:0]  mem_row  [DEPTH];
  logic [TAG_W-1:0]  mem_tag  [DEPTH];
  logic [DEPTH-1:0]  mem_eob;

  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count, closed_cnt;
  logic              open_q;
  logic [BANK_W-1:0] open_bank;
  logic [ROW_W-1:0]  open_row;
  logic [WIN_W-1:0]  win_cnt;

  // Named internal events
  logic push, pop, key_break, win_expire, close_old, new_eob, starts_new;
  logic [AW-1:0] tail_ptr;

  assign in_ready   = (count != CW'(DEPTH));
  assign push       = in_valid & in_ready;
  assign out_valid  = (closed_cnt != '0);
  assign pop        = out_valid & out_ready;
  assign key_break  = push & ((in_bank != open_bank) | (in_row != open_row));
  assign win_expire = open_q & window_done(32'(win_cnt), 32'(window_len));
  assign close_old  = open_q & (key_break | win_expire | bypass);
  assign new_eob    = bypass | single_shot(32'(window_len));
  assign starts_new = push & (~open_q | close_old);
  assign tail_ptr   = wr_ptr - AW'(1);

  assign out_last  = mem_eob[rd_ptr];
  assign out_bank  = mem_bank[rd_ptr];
  assign out_row   = mem_row[rd_ptr];
  assign out_tag   = mem_tag[rd_ptr];
  assign occupancy = count;

  always_ff @(posedge clk) begin
    if (push) begin
      mem_bank[wr_ptr] <= in_bank;
      mem_row[wr_ptr]  <= in_row;
      mem_tag[wr_ptr]  <= in_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      closed_cnt <= '0;
      open_q     <= 1'b0;
      open_bank  <= '0;
      open_row   <= '0;
      win_cnt    <= '0;
      mem_eob    <= '0;
    end else begin
      if (push) begin
        mem_eob[wr_ptr] <= new_eob;
        wr_ptr          <= wr_ptr + AW'(1);
        open_bank       <= in_bank;
        open_row        <= in_row;
      end
      if (close_old) mem_eob[tail_ptr] <= 1'b1;
      if (pop) rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(push) - CW'(pop);
      closed_cnt <= closed_cnt + CW'(close_old) + CW'(push & new_eob)
                    - CW'(pop & mem_eob[rd_ptr]);
      if (push)           open_q <= ~new_eob;
      else if (close_old) open_q <= 1'b0;
      if (starts_new)  win_cnt <= '0;
      else if (open_q) win_cnt <= win_cnt + WIN_W'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !pop) |=> !in_ready); // R6
  AST_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (count != '0)); // R4
  AST_ROW_BREAK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && key_break) |=> out_valid); // R2
  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> out_valid); // R3
  AST_BYPASS_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && push) |=> out_valid); // R5

endmodule

// File: rtl/rowgroup_former.sv
module rowgroup_former #(
  parameter int NSRC   = 5,
  parameter int DEPTH  = 16,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int TAG_W  = 6,
  parameter int WIN_W  = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int TOT_W = $clog2(NSRC * DEPTH + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WIN_W-1:0]       window_len,
  input  logic [TOT_W-1:0]       bypass_below,
  input  logic [NSRC-1:0]        in_valid,
  output logic [NSRC-1:0]        in_ready,
  input  logic [NSRC*BANK_W-1:0] in_bank,
  input  logic [NSRC*ROW_W-1:0]  in_row,
  input  logic [NSRC*TAG_W-1:0]  in_tag,
  output logic [NSRC-1:0]        out_valid,
  input  logic [NSRC-1:0]        out_ready,
  output logic [NSRC-1:0]        out_last,
  output logic [NSRC*BANK_W-1:0] out_bank,
  output logic [NSRC*ROW_W-1:0]  out_row,
  output logic [NSRC*TAG_W-1:0]  out_tag
);

  logic [NSRC*CW-1:0] occ;
  logic [TOT_W-1:0]   total;
  logic               bypass;

  rgf_load_gauge #(.NSRC(NSRC), .CW(CW), .TOT_W(TOT_W)) u_gauge (
    .occ(occ), .thr(bypass_below), .total(total), .bypass(bypass)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    rgf_src_queue #(
      .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W), .WIN_W(WIN_W)
    ) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .bypass     (bypass),
      .window_len (window_len),
      .in_valid   (in_valid[s]),
      .in_ready   (in_ready[s]),
      .in_bank    (in_bank[s*BANK_W +: BANK_W]),
      .in_row     (in_row[s*ROW_W +: ROW_W]),
      .in_tag     (in_tag[s*TAG_W +: TAG_W]),
      .out_valid  (out_valid[s]),
      .out_ready  (out_ready[s]),
      .out_last   (out_last[s]),
      .out_bank   (out_bank[s*BANK_W +: BANK_W]),
      .out_row    (out_row[s*ROW_W +: ROW_W]),
      .out_tag    (out_tag[s*TAG_W +: TAG_W]),
      .occupancy  (occ[s*CW +: CW])
    );
  end

  AST_BYPASS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (total >= bypass_below) |-> !bypass); // R5

endmodule

// File: tb/rowgroup_former_bench.sv
`timescale 1ns/1ps
module rowgroup_former_bench;
  localparam int NSRC = 3, DEPTH = 8, BANK_W = 2, ROW_W = 4, TAG_W = 6, WIN_W = 4;
  localparam int TOT_W = $clog2(NSRC * DEPTH + 1) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [WIN_W-1:0] window_len = 4'd15;
  logic [TOT_W-1:0] bypass_below = '0;
  logic [NSRC-1:0] in_valid = '0, in_ready, out_valid, out_ready = '0, out_last;
  logic [NSRC*BANK_W-1:0] in_bank = '0, out_bank;
  logic [NSRC*ROW_W-1:0]  in_row = '0, out_row;
  logic [NSRC*TAG_W-1:0]  in_tag = '0, out_tag;

  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  rowgroup_former #(.NSRC(NSRC), .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
                    .TAG_W(TAG_W), .WIN_W(WIN_W)) u_rowgroup_former (
    .clk(clk), .rst_n(rst_n), .window_len(window_len), .bypass_below(bypass_below),
    .in_valid(in_valid), .in_ready(in_ready), .in_bank(in_bank), .in_row(in_row),
    .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .out_bank(out_bank), .out_row(out_row), .out_tag(out_tag));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_req(input int s, input int b, input int r, input int t);
    in_valid[s] = 1'b1;
    in_bank[s*BANK_W +: BANK_W] = BANK_W'(b);
    in_row[s*ROW_W +: ROW_W]    = ROW_W'(r);
    in_tag[s*TAG_W +: TAG_W]    = TAG_W'(t);
  endtask

  task automatic push1(input int s, input int b, input int r, input int t);
    set_req(s, b, r, t);
    @(negedge clk);
    in_valid[s] = 1'b0;
  endtask

  // Pop the head of source s and check its tag and last flag.
  task automatic pop_chk(input int s, input int etag, input bit elast, input string req);
    check(out_valid[s] == 1'b1, req, int'(out_valid[s]), 1);
    check(int'(out_tag[s*TAG_W +: TAG_W]) == etag, req, int'(out_tag[s*TAG_W +: TAG_W]), etag);
    check(out_last[s] == elast, req, int'(out_last[s]), int'(elast));
    out_ready[s] = 1'b1;
    @(negedge clk);
    out_ready[s] = 1'b0;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R7: reset state
    check(out_valid == '0, "R7 out_valid", int'(out_valid), 0);
    check(in_ready == '1, "R7 in_ready", int'(in_ready), 7);

    // R2 / R4: row-break sweep over run lengths
    for (int k = 1; k < DEPTH; k++) begin
      for (int i = 0; i < k; i++) push1(0, 1, k, i);
      check(out_valid[0] == 1'b0, "R4 open batch hidden", int'(out_valid[0]), 0);
      push1(0, 1, k + 1, 40);
      check(out_valid[0] == 1'b1, "R2 row change closes", int'(out_valid[0]), 1);
      for (int i = 0; i < k; i++) pop_chk(0, i, i == k - 1, "R4 run order/last");
      check(out_valid[0] == 1'b0, "R4 break entry still open", int'(out_valid[0]), 0);
      idle(16);
      pop_chk(0, 40, 1'b1, "R3 expired tail");
    end

    // R2: same row, different bank
    push1(0, 0, 5, 11);
    push1(0, 1, 5, 12);
    check(out_valid[0] == 1'b1, "R2 bank change closes", int'(out_valid[0]), 1);
    pop_chk(0, 11, 1'b1, "R2 bank batch");
    idle(16);
    pop_chk(0, 12, 1'b1, "R2 bank second");

    // R3: window sweep
    for (int L = 1; L <= 6; L++) begin
      window_len = WIN_W'(L);
      push1(1, 2, 9, L);
      if (L >= 2) begin
        idle(L - 1);
        check(out_valid[1] == 1'b0, "R3 before window", int'(out_valid[1]), 0);
      end
      idle(1);
      check(out_valid[1] == 1'b1, "R3 at window", int'(out_valid[1]), 1);
      pop_chk(1, L, 1'b1, "R3 window batch");
    end
    window_len = 4'd15;

    // R1: two sources interleaved, third untouched
    set_req(1, 0, 3, 1); set_req(2, 0, 7, 21); @(negedge clk);
    set_req(1, 0, 3, 2); set_req(2, 0, 8, 22); @(negedge clk);
    in_valid[2] = 1'b0;
    set_req(1, 0, 4, 3); @(negedge clk);
    in_valid[1] = 1'b0;
    check(out_valid[0] == 1'b0, "R1 idle source", int'(out_valid[0]), 0);
    pop_chk(1, 1, 1'b0, "R1 src1 order");
    pop_chk(1, 2, 1'b1, "R1 src1 order");
    pop_chk(2, 21, 1'b1, "R1 src2 order");
    idle(16);
    pop_chk(1, 3, 1'b1, "R1 src1 tail");
    pop_chk(2, 22, 1'b1, "R1 src2 tail");

    // R6: fill, drop, simultaneous enqueue and dequeue
    for (int i = 0; i < DEPTH; i++) push1(2, 3, 2, i);
    check(in_ready[2] == 1'b0, "R6 full", int'(in_ready[2]), 0);
    push1(2, 3, 2, 9);
    idle(16);
    pop_chk(2, 0, 1'b0, "R6 head");
    check(in_ready[2] == 1'b1, "R6 ready after pop", int'(in_ready[2]), 1);
    set_req(2, 3, 6, 20);
    out_ready[2] = 1'b1;
    @(negedge clk);
    in_valid[2] = 1'b0; out_ready[2] = 1'b0;
    for (int i = 2; i < DEPTH; i++) pop_chk(2, i, i == DEPTH - 1, "R6 drain order");
    check(out_valid[2] == 1'b0, "R6 dropped request absent", int'(out_valid[2]), 0);
    idle(16);
    pop_chk(2, 20, 1'b1, "R6 simultaneous enqueue kept");

    // R5: bypass threshold boundary
    push1(1, 1, 1, 30);
    push1(1, 1, 1, 31);
    bypass_below = TOT_W'(2);
    idle(1);
    check(out_valid[1] == 1'b0, "R5 equal total no bypass", int'(out_valid[1]), 0);
    bypass_below = TOT_W'(3);
    idle(1);
    check(out_valid[1] == 1'b1, "R5 bypass closes open batch", int'(out_valid[1]), 1);
    pop_chk(1, 30, 1'b0, "R5 batch order");
    pop_chk(1, 31, 1'b1, "R5 batch last");
    push1(1, 1, 1, 32);
    check(out_valid[1] == 1'b1, "R5 forward next cycle", int'(out_valid[1]), 1);
    pop_chk(1, 32, 1'b1, "R5 single request");
    bypass_below = '0;

    report();
  end
endmodule